// File: doc/BRIEF.md
# Module presence-detect byte store with two-wire target

This block is a two-wire (I2C) target holding a 256-byte identification store for a memory module. A bus controller selects it with a 7-bit device address. The upper four bits of that address are fixed. The lower three bits come from strap pins. The controller then reads or writes single bytes. It can set the internal word pointer with a dummy write and a repeated START, then read from that address. It can also read from wherever the pointer already stands. Reads may run on through the store. The pointer wraps from the last byte to the first.

The lower half of the store is the identification area. A lock input guards it against writes. The upper half is free user space. After reset the contents come from parameters:
- Bytes 0 to 62 follow an arithmetic pattern.
- Byte 63 holds the mod-256 sum of bytes 0 to 62.
- Bytes 64 to 127 are zero.
- The user half reads 0xFF.

A background scanner keeps re-adding bytes 0 to 62 and compares the sum with byte 63. A mismatch raises a sticky flag.

The serial clock and data lines are sampled with the system clock. The data line comes in and goes out as separate signals: an input, a driven value that is always low, and an output enable. A pad outside the block makes these open-drain. The bus is the only data path and it paces itself through the serial clock, so there is no valid/ready interface. The strap, lock and flag pins are plain levels.

Top module: `spd_eeprom_target`

## Requirements
- R1: The block acknowledges a device-address byte only when its upper seven bits equal {4'b1010, sa_i}. For any other address it leaves the data line released for the acknowledge bit and for the rest of that transfer.
- R2: A write of a word address, then a repeated START and a read-addressed device byte (bit 0 = 1), returns the byte stored at that word address. The repeated START does not move the pointer.
- R3: During a read, each byte the controller acknowledges (data line low in the ninth bit) advances the pointer by one, and address 255 is followed by address 0. A not-acknowledge ends the read.
- R4: After reset, byte i holds (ID_BASE + i*ID_STEP) mod 256 for i < 63. Byte 63 holds the mod-256 sum of bytes 0..62, XORed with CSUM_SKEW. Bytes 64..127 hold 0x00 and bytes 128..255 hold 0xFF. With the defaults, ID_BASE = 0x40, ID_STEP = 0x07 and CSUM_SKEW = 0x00.
- R5: A data byte written to an address of 128 or above is acknowledged and stored, whatever the lock input is.
- R6: While wr_lock_i is 1, a data byte aimed at an address below 128 is acknowledged but not stored. While wr_lock_i is 0, it is stored.
- R7: Only the first data byte of a write transfer is taken. Any further data byte in the same transfer is not acknowledged and not stored.
- R8: After a write, the pointer stands at the written address plus one, modulo 256. A read with no word address that follows returns the byte found there.
- R9: csum_err_o is 0 after reset while bytes 0..63 agree. It rises within 130 clock cycles after a stored change makes the sum of bytes 0..62 differ from byte 63. Once high, it stays high until reset, even if the contents agree again.
- R10: sda_oe changes only while the sampled serial clock is low. sda_oe is 0 whenever the bus engine is idle, and sda_o is always 0.
- R11: Reset releases the data line, clears csum_err_o and restores the preload contents of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_o | output | 1 | Value driven onto the data line (always 0) |
| sda_oe | output | 1 | 1 pulls the data line low |
| sa_i | input | 3 | Strap bits forming the low device-address bits |
| wr_lock_i | input | 1 | 1 protects bytes 0..127 from writes |
| csum_err_o | output | 1 | Sticky identification checksum mismatch |

## Verification
The assertions assume that the bus is slow against the system clock. Each serial-clock phase must last several system cycles, so that a change of the data line driven by the block settles before the serial clock rises again. They also assume the controller never signals START or STOP while the block holds the line low. The bench master keeps every serial-clock phase at ten system cycles and changes the data line only in the middle of a low phase, except for deliberate START and STOP conditions. It releases the line whenever the block owns the acknowledge or data bits. The bench sweeps every 7-bit device address and reads the whole store, across the wrap, in one sequential burst.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACK,
    S_WADR,
    S_WADR_ACK,
    S_WDAT,
    S_WDAT_ACK,
    S_HOLD,
    S_RD,
    S_RD_ACK
  } bus_state_t;

  // Reset content of one byte of the store.
  function automatic logic [7:0] preload_byte(input int idx, input logic [7:0] base,
                                              input logic [7:0] step, input logic [7:0] skew,
                                              input int csum_pos, input int half);
    logic [7:0] sum;
    sum = 8'h00;
    if (idx < csum_pos) begin
      return base + 8'(idx) * step;
    end
    if (idx == csum_pos) begin
      for (int j = 0; j < csum_pos; j++) begin
        sum = sum + base + 8'(j) * step;
      end
      return sum ^ skew;
    end
    if (idx < half) begin
      return 8'h00;
    end
    return 8'hFF;
  endfunction

endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  // bit 1 = clock line, bit 0 = data line
  logic [1:0] pipe [STAGES];
  logic [1:0] prev;
  logic [1:0] cur;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= 2'b11;
          else        pipe[0] <= {scl_i, sda_i};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= 2'b11;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign cur = pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 2'b11;
    else        prev <= cur;
  end

  assign scl_q    = cur[1];
  assign sda_q    = cur[0];
  assign scl_rise = ~prev[1] & cur[1];
  assign scl_fall = prev[1] & ~cur[1];
  assign start_ev = prev[1] & cur[1] & prev[0] & ~cur[0];
  assign stop_ev  = prev[1] & cur[1] & ~prev[0] & cur[0];

endmodule

// File: rtl/spd_store.sv
module spd_store
  import spd_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         CSUM_POS  = 63,
  parameter int         SCAN_W    = 6,
  parameter logic [7:0] ID_BASE   = 8'h40,
  parameter logic [7:0] ID_STEP   = 8'h07,
  parameter logic [7:0] CSUM_SKEW = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [SCAN_W-1:0] scan_addr,
  output logic [7:0]        scan_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= preload_byte(i, ID_BASE, ID_STEP, CSUM_SKEW, CSUM_POS, HALF);
      end
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data   = mem[rd_addr];
  assign scan_data = mem[ADDR_W'(scan_addr)];

endmodule

// File: rtl/spd_csum_scan.sv
module spd_csum_scan #(
  parameter int CSUM_POS = 63,
  parameter int SCAN_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        scan_data,
  output logic [SCAN_W-1:0] scan_addr,
  output logic              csum_err
);
  localparam logic [SCAN_W-1:0] LAST = SCAN_W'(CSUM_POS);

  logic [7:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_addr <= '0;
      acc       <= 8'h00;
      csum_err  <= 1'b0;
    end else if (scan_addr == LAST) begin
      if (acc != scan_data) csum_err <= 1'b1;
      acc       <= 8'h00;
      scan_addr <= '0;
    end else begin
      acc       <= acc + scan_data;
      scan_addr <= scan_addr + 1'b1;
    end
  end

endmodule

// File: rtl/spd_bus_fsm.sv
module spd_bus_fsm
  import spd_pkg::*;
#(
  parameter int         ADDR_W = 8,
  parameter logic [3:0] DEV_HI = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_q,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [2:0]        sa_i,
  input  logic              wr_lock_i,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              sda_oe,
  output logic              idle
);
  bus_state_t state;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       rd_mode;
  logic       ctl_nack;
  logic       byte_done;
  logic       dev_hit;

  assign byte_done = scl_fall && (bitcnt == 4'd8);
  assign dev_hit   = (shreg[7:1] == {DEV_HI, sa_i});
  assign wr_addr   = ptr;
  assign wr_data   = shreg;
  assign idle      = (state == S_IDLE);
  assign wr_en     = (state == S_WDAT) && byte_done && !start_ev && !stop_ev &&
                     (!wr_lock_i || ptr[ADDR_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bitcnt   <= 4'd0;
      shreg    <= 8'h00;
      ptr      <= '0;
      rd_mode  <= 1'b0;
      ctl_nack <= 1'b1;
      sda_oe   <= 1'b0;
    end else if (stop_ev) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      state  <= S_DEV;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_DEV, S_WADR, S_WDAT: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            if (state == S_DEV) begin
              if (dev_hit) begin
                sda_oe  <= 1'b1;
                rd_mode <= shreg[0];
                state   <= S_DEV_ACK;
              end else begin
                state <= S_IDLE;
              end
            end else if (state == S_WADR) begin
              sda_oe <= 1'b1;
              ptr    <= ADDR_W'(shreg);
              state  <= S_WADR_ACK;
            end else begin
              sda_oe <= 1'b1;
              ptr    <= ptr + 1'b1;
              state  <= S_WDAT_ACK;
            end
          end
        end
        S_DEV_ACK: begin
          if (scl_fall) begin
            bitcnt <= 4'd0;
            if (rd_mode) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_WADR;
            end
          end
        end
        S_WADR_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= 4'd0;
            state  <= S_WDAT;
          end
        end
        S_WDAT_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= S_HOLD;
          end
        end
        S_RD: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
              state  <= S_RD_ACK;
            end else begin
              sda_oe <= ~shreg[6];
              shreg  <= {shreg[6:0], 1'b0};
            end
          end
        end
        S_RD_ACK: begin
          if (scl_rise) begin
            ctl_nack <= sda_q;
          end else if (scl_fall) begin
            if (!ctl_nack) begin
              bitcnt <= 4'd0;
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_HOLD;
            end
          end
        end
        S_HOLD, S_IDLE: begin
          sda_oe <= 1'b0;
        end
        default: begin
          state  <= S_IDLE;
          sda_oe <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/spd_eeprom_target.sv
module spd_eeprom_target #(
  parameter int         ADDR_W      = 8,
  parameter int         CSUM_POS    = 63,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_HI      = 4'b1010,
  parameter logic [7:0] ID_BASE     = 8'h40,
  parameter logic [7:0] ID_STEP     = 8'h07,
  parameter logic [7:0] CSUM_SKEW   = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       sda_oe,
  input  logic [2:0] sa_i,
  input  logic       wr_lock_i,
  output logic       csum_err_o
);
  localparam int SCAN_W = $clog2(CSUM_POS + 1);

  logic              scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;
  logic [ADDR_W-1:0] ptr, wr_addr;
  logic [7:0]        rd_data, wr_data, scan_data;
  logic              wr_en, fsm_idle;
  logic [SCAN_W-1:0] scan_addr;

  assign sda_o = 1'b0;

  spd_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  spd_bus_fsm #(.ADDR_W(ADDR_W), .DEV_HI(DEV_HI)) fsm_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_q(sda_q), .start_ev(start_ev), .stop_ev(stop_ev), .sa_i(sa_i),
    .wr_lock_i(wr_lock_i), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe), .idle(fsm_idle)
  );

  spd_store #(
    .ADDR_W(ADDR_W), .CSUM_POS(CSUM_POS), .SCAN_W(SCAN_W),
    .ID_BASE(ID_BASE), .ID_STEP(ID_STEP), .CSUM_SKEW(CSUM_SKEW)
  ) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data), .scan_addr(scan_addr), .scan_data(scan_data)
  );

  spd_csum_scan #(.CSUM_POS(CSUM_POS), .SCAN_W(SCAN_W)) scan_i (
    .clk(clk), .rst_n(rst_n), .scan_data(scan_data), .scan_addr(scan_addr),
    .csum_err(csum_err_o)
  );

endmodule

// File: rtl/spd_eeprom_chk.sv
module spd_eeprom_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_q,
  input logic              csum_err_o,
  input logic              fsm_idle,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_lock_i
);
  // R10: the data line is only turned around while the clock is low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_q));

  // R10: an idle engine never holds the line
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_idle |-> !sda_oe);

  // R9: the mismatch flag never drops without reset
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csum_err_o |=> csum_err_o);

  // R6: no store into the identification half while locked
  p_lock_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_lock_i) |-> wr_addr[ADDR_W-1]);

  // R1: a store happens only inside an addressed transfer
  p_write_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !fsm_idle);

endmodule

bind spd_eeprom_target spd_eeprom_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_q(scl_q),
  .csum_err_o(csum_err_o), .fsm_idle(fsm_idle), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_lock_i(wr_lock_i)
);

// File: tb/spd_eeprom_target_tb_top.sv
module spd_eeprom_target_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] sa = 3'b101;
  logic lock = 1'b1;
  wire sda_o, sda_oe, csum_err;
  wire sda_bus = m_sda & (sda_oe ? sda_o : 1'b1);

  localparam logic [6:0] DEV = {4'b1010, 3'b101};

  int n_tests = 0;
  int n_fail = 0;
  logic [7:0] exp_mem [256];

  always #5 clk = ~clk;

  spd_eeprom_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_o(sda_o),
    .sda_oe(sda_oe), .sa_i(sa), .wr_lock_i(lock), .csum_err_o(csum_err)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic model_reset();
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < 256; i++) begin
      if (i < 63) begin
        exp_mem[i] = 8'((64 + 7 * i) % 256);
        s = s + exp_mem[i];
      end else if (i == 63) exp_mem[i] = s;
      else if (i < 128) exp_mem[i] = 8'h00;
      else exp_mem[i] = 8'hFF;
    end
  endtask

  task automatic b_start();
    m_sda = 1'b1; wt(5);
    m_scl = 1'b1; wt(5);
    m_sda = 1'b0; wt(5);
    m_scl = 1'b0; wt(5);
  endtask

  task automatic b_stop();
    m_sda = 1'b0; wt(5);
    m_scl = 1'b1; wt(5);
    m_sda = 1'b1; wt(10);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wt(5);
    m_scl = 1'b1; wt(10);
    m_scl = 1'b0; wt(5);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wt(5);
    m_scl = 1'b1; wt(5);
    b = sda_bus; wt(5);
    m_scl = 1'b0; wt(5);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~ack);
  endtask

  task automatic rd_at(input logic [7:0] a, output logic [7:0] d);
    logic k0, k1, k2;
    b_start(); wbyte({DEV, 1'b0}, k0); wbyte(a, k1);
    b_start(); wbyte({DEV, 1'b1}, k2); rbyte(d, 1'b0); b_stop();
    chk(k0 && k1 && k2, "R2 random read acks", {k0, k1, k2}, 3'b111);
  endtask

  task automatic wr_at(input logic [7:0] a, input logic [7:0] d);
    logic k0, k1, k2;
    b_start(); wbyte({DEV, 1'b0}, k0); wbyte(a, k1); wbyte(d, k2); b_stop();
    chk(k0 && k1 && k2, "R5 write acks", {k0, k1, k2}, 3'b111);
  endtask

  task automatic cur_rd(output logic [7:0] d);
    logic k0;
    b_start(); wbyte({DEV, 1'b1}, k0); rbyte(d, 1'b0); b_stop();
    chk(k0, "R8 current read ack", k0, 1);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic ack;
    logic [7:0] orig;
    model_reset();
    wt(4);
    rst_n = 1'b1;
    wt(10);
    // R11 reset state
    chk(sda_oe == 1'b0, "R11 line released", sda_oe, 0);
    chk(csum_err == 1'b0, "R11 flag clear", csum_err, 0);
    wt(200);
    chk(csum_err == 1'b0, "R9 consistent contents keep flag low", csum_err, 0);

    // R1 sweep of every device address
    for (int a = 0; a < 128; a++) begin
      b_start();
      wbyte({7'(a), 1'b0}, ack);
      b_stop();
      chk(ack == (7'(a) == DEV), "R1 device address match", ack, (7'(a) == DEV));
    end

    // R3/R4 one burst over the whole store, across the wrap
    b_start(); wbyte({DEV, 1'b0}, ack); wbyte(8'h00, ack);
    b_start(); wbyte({DEV, 1'b1}, ack);
    chk(ack, "R2 read device ack after repeated start", ack, 1);
    for (int i = 0; i < 258; i++) begin
      rbyte(d, i != 257);
      chk(d == exp_mem[i % 256], (i >= 256) ? "R3 wrap to byte 0" : "R4 preload byte",
          d, exp_mem[i % 256]);
    end
    b_stop();
    chk(sda_oe == 1'b0, "R3 released after controller nack", sda_oe, 0);

    // R2 random reads
    rd_at(8'd200, d); chk(d == exp_mem[200], "R2 byte 200", d, exp_mem[200]);
    rd_at(8'd63, d);  chk(d == exp_mem[63], "R2 byte 63", d, exp_mem[63]);

    // R5 user half with lock high
    lock = 1'b1;
    wr_at(8'hC0, 8'h5A); exp_mem[8'hC0] = 8'h5A;
    rd_at(8'hC0, d); chk(d == 8'h5A, "R5 user byte stored under lock", d, 8'h5A);

    // R7 extra data byte refused
    b_start(); wbyte({DEV, 1'b0}, ack); wbyte(8'hD0, ack);
    wbyte(8'h11, ack); chk(ack, "R7 first data byte ack", ack, 1);
    wbyte(8'h22, ack); chk(!ack, "R7 second data byte nack", ack, 0);
    b_stop();
    exp_mem[8'hD0] = 8'h11;
    rd_at(8'hD0, d); chk(d == 8'h11, "R7 first byte kept", d, 8'h11);
    rd_at(8'hD1, d); chk(d == 8'hFF, "R7 second byte dropped", d, 8'hFF);

    // R8 pointer after write
    wr_at(8'h91, 8'h3C);
    wr_at(8'h90, 8'hA5);
    cur_rd(d); chk(d == 8'h3C, "R8 pointer at address plus one", d, 8'h3C);
    wr_at(8'hFF, 8'h77);
    cur_rd(d); chk(d == exp_mem[0], "R8 pointer wraps after byte 255", d, exp_mem[0]);

    // R6 locked identification half
    wr_at(8'h05, 8'hAA);
    rd_at(8'h05, d); chk(d == exp_mem[5], "R6 locked write discarded", d, exp_mem[5]);
    wt(200);
    chk(csum_err == 1'b0, "R9 flag low after discarded write", csum_err, 0);

    // R6/R9 unlocked write breaks checksum
    lock = 1'b0;
    orig = exp_mem[10];
    wr_at(8'h0A, orig ^ 8'h01);
    rd_at(8'h0A, d); chk(d == (orig ^ 8'h01), "R6 unlocked write stored", d, orig ^ 8'h01);
    wt(130);
    chk(csum_err == 1'b1, "R9 flag raised on mismatch", csum_err, 1);
    wr_at(8'h0A, orig);
    wt(200);
    chk(csum_err == 1'b1, "R9 flag sticky after repair", csum_err, 1);

    // R11 reset restores preload
    rst_n = 1'b0; wt(3); rst_n = 1'b1; wt(5);
    chk(csum_err == 1'b0, "R11 flag cleared by reset", csum_err, 0);
    rd_at(8'h91, d); chk(d == 8'hFF, "R11 user byte restored", d, 8'hFF);
    rd_at(8'h0A, d); chk(d == orig, "R11 id byte restored", d, orig);
    wt(200);
    chk(csum_err == 1'b0, "R9 flag low after reset", csum_err, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule